// File: doc/BRIEF.md
# Restartable Four-Pulse Timer

A small synchronous Moore machine that paces a short, fixed run of clock pulses.
While it waits it shows a count of 100 with the beeper silent. Raising the restart
input freezes the timer at 000. Releasing restart starts a count that shows 000,
001, 010 and 011, one clock each. The count ends with one clock of 100 with the
beeper on, and the timer then falls back to waiting.

The count and beeper outputs are decoded only from the registered state, so a
change on restart is seen only at the next rising edge. A restart raised at any
point of the count sends the timer back to the frozen hold, and the full count
starts again when restart is released. The state is held in three flip-flops.
Seven codes are in use, and the one spare code leads to the waiting state.

Top module: `fourpulse_timer`

## Requirements
- R1: The count and beeper outputs depend only on the registered state. A change on restart_i between clock edges leaves cnt_o and beep_o unchanged until the next rising edge.
- R2: In the waiting state cnt_o is 3'b100 and beep_o is 0. The timer stays there on every edge at which restart_i is 0.
- R3: From the waiting state, restart_i=1 at an edge leads to the hold state, where cnt_o is 3'b000 and beep_o is 0. The hold state is kept on every edge with restart_i=1.
- R4: restart_i=1 sampled on an edge during any count step leads to the hold state (cnt_o=3'b000, beep_o=0) after that edge.
- R5: From hold, restart_i=0 at an edge starts the count. With restart_i held at 0, the count shows cnt_o 3'b000, 3'b001, 3'b010, 3'b011 on successive cycles, with beep_o 0 in each.
- R6: After the 3'b011 step, and with restart_i=0, the next cycle shows cnt_o=3'b100 with beep_o=1 for exactly one clock. The cycle after that is the waiting state (cnt_o=3'b100, beep_o=0).
- R7: beep_o is 1 only in the final count step. Whenever beep_o is 1, cnt_o is 3'b100.
- R8: rst_i=1 at a rising edge puts the timer in the waiting state (3'b100, beep 0) after that edge, whatever the value of restart_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| restart_i | input | 1 | Restart request, active high, sampled on the rising edge |
| cnt_o | output | 3 | Count display decoded from the state |
| beep_o | output | 1 | Beeper, high only in the last count step |

## Verification
The checker tests several rules on every cycle. It checks that restart always leads to 000 with the beeper off, that the waiting state persists, and that each middle count step advances by one. It also checks that the beeper appears only with 100 and lasts a single clock before waiting, and that reset leads to waiting. Some behaviour needs the bench's scenarios. The bench shows that outputs ignore restart between edges, and that hold persists over a long run with restart high. It shows that a restart at each count step leads back to hold. A sweep over every 8-cycle restart pattern compares each cycle against a mode and step model.

// File: rtl/fourpulse_timer_pkg.sv
package fourpulse_timer_pkg;
    localparam int unsigned ST_W  = 3;
    localparam int unsigned CNT_W = 3;

    // The count steps are encoded with their displayed value, so that the decode stays trivial.
    typedef enum logic [ST_W-1:0] {
        ST_C0    = 3'd0,
        ST_C1    = 3'd1,
        ST_C2    = 3'd2,
        ST_C3    = 3'd3,
        ST_C4    = 3'd4,
        ST_IDLE  = 3'd5,
        ST_HOLD  = 3'd6,
        ST_SPARE = 3'd7
    } tmr_state_e;

    typedef struct packed {
        tmr_state_e state;
    } tmr_reg_t;

    localparam logic [CNT_W-1:0] IDLE_SHOW = 3'b100;
    localparam logic [CNT_W-1:0] HOLD_SHOW = 3'b000;
endpackage

// File: rtl/timer_next.sv
module timer_next
    import fourpulse_timer_pkg::*;
(
    input  tmr_state_e state_q,
    input  logic       restart_i,
    output tmr_state_e state_d
);
    always_comb begin
        state_d = ST_IDLE;
        case (state_q)
            ST_IDLE:  state_d = restart_i ? ST_HOLD : ST_IDLE;
            ST_HOLD:  state_d = restart_i ? ST_HOLD : ST_C0;
            ST_C0:    state_d = restart_i ? ST_HOLD : ST_C1;
            ST_C1:    state_d = restart_i ? ST_HOLD : ST_C2;
            ST_C2:    state_d = restart_i ? ST_HOLD : ST_C3;
            ST_C3:    state_d = restart_i ? ST_HOLD : ST_C4;
            ST_C4:    state_d = restart_i ? ST_HOLD : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/timer_out.sv
module timer_out
    import fourpulse_timer_pkg::*;
(
    input  tmr_state_e       state_q,
    output logic [CNT_W-1:0] cnt_o,
    output logic             beep_o
);
    always_comb begin
        cnt_o  = IDLE_SHOW;
        beep_o = 1'b0;
        case (state_q)
            ST_HOLD: cnt_o = HOLD_SHOW;
            ST_C0, ST_C1, ST_C2, ST_C3: cnt_o = CNT_W'(state_q);
            ST_C4: begin
                cnt_o  = CNT_W'(state_q);
                beep_o = 1'b1;
            end
            default: cnt_o = IDLE_SHOW;
        endcase
    end
endmodule

// File: rtl/fourpulse_timer.sv
module fourpulse_timer
    import fourpulse_timer_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       restart_i,
    output logic [2:0] cnt_o,
    output logic       beep_o
);
    tmr_reg_t   reg_d, reg_q;
    tmr_state_e nxt_state;

    timer_next next_i (
        .state_q   (reg_q.state),
        .restart_i (restart_i),
        .state_d   (nxt_state)
    );

    always_comb begin
        reg_d = reg_q;
        reg_d.state = rst_i ? ST_IDLE : nxt_state;
    end

    always_ff @(posedge clk_i) begin
        reg_q <= reg_d;
    end

    timer_out out_i (
        .state_q (reg_q.state),
        .cnt_o   (cnt_o),
        .beep_o  (beep_o)
    );
endmodule

// File: rtl/timer_chk.sv
module timer_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       restart_i,
    input logic [2:0] cnt_o,
    input logic       beep_o
);
    logic seen_q = 1'b0;
    always_ff @(posedge clk_i) begin
        if (rst_i) seen_q <= 1'b1;
    end

    AST_RESTART_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && restart_i) |=> (cnt_o == 3'b000 && !beep_o)); // R4
    AST_IDLE_STAY: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && cnt_o == 3'b100 && !beep_o && !restart_i) |=> (cnt_o == 3'b100 && !beep_o)); // R2
    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && !restart_i && cnt_o != 3'b000 && cnt_o < 3'b100)
        |=> (cnt_o == 3'($past(cnt_o) + 3'd1))); // R5
    AST_BEEP_ONCE: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && beep_o && !restart_i) |=> (cnt_o == 3'b100 && !beep_o)); // R6
    AST_BEEP_SHOW: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && beep_o) |-> (cnt_o == 3'b100)); // R7
    AST_RESET_IDLE: assert property (@(posedge clk_i)
        rst_i |=> (cnt_o == 3'b100 && !beep_o)); // R8
endmodule

bind fourpulse_timer timer_chk chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (restart_i),
    .cnt_o     (cnt_o),
    .beep_o    (beep_o)
);

// File: tb/fourpulse_timer_tb.sv
module fourpulse_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       restart = 1'b0;
    logic [2:0] cnt;
    logic       beep;
    int n_chk = 0;
    int n_err = 0;

    // Model: mode 0 waiting, 1 hold, 2 counting at step k (0..4)
    int mode = 0;
    int k = 0;

    always #5 clk = ~clk;

    fourpulse_timer dut_i (
        .clk_i(clk), .rst_i(rst), .restart_i(restart), .cnt_o(cnt), .beep_o(beep)
    );

    function automatic logic [2:0] exp_cnt();
        if (mode == 0) return 3'b100;
        if (mode == 1) return 3'b000;
        return 3'(k);
    endfunction

    function automatic logic exp_beep();
        return (mode == 2 && k == 4);
    endfunction

    task automatic check(input string tag);
        n_chk++;
        if (cnt !== exp_cnt() || beep !== exp_beep()) begin
            n_err++;
            $display("FAIL %s: cnt=%b beep=%b expected cnt=%b beep=%b",
                     tag, cnt, beep, exp_cnt(), exp_beep());
        end
    endtask

    function automatic string auto_tag(input logic r_was);
        if (r_was) return (mode == 1) ? "R4" : "R4?";
        if (mode == 0) return (k == 5) ? "R6" : "R2";
        if (mode == 2 && k == 4) return "R6";
        return "R5";
    endfunction

    // One clock with restart=r; model update; check after the edge.
    task automatic step(input logic r, input string tag);
        restart = r;
        @(posedge clk);
        if (r) begin mode = 1; k = 0; end
        else if (mode == 0) k = 0;
        else if (mode == 1) begin mode = 2; k = 0; end
        else if (k == 4) begin mode = 0; k = 5; end
        else k = k + 1;
        @(negedge clk);
        check(tag == "" ? auto_tag(r) : tag);
        if (mode == 0) k = 0;
    endtask

    task automatic do_reset(input logic r);
        rst = 1'b1; restart = r;
        @(posedge clk);
        mode = 0; k = 0;
        @(negedge clk);
        check("R8");
        rst = 1'b0; restart = 1'b0;
    endtask

    initial begin
        #2000000;
        n_err++;
        $display("FAIL watchdog: run did not end, expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, "R2");
        step(1'b1, "R3");
        for (int i = 0; i < 20; i++) step(1'b1, "R3");
        for (int i = 0; i < 4; i++) step(1'b0, "R5");
        step(1'b0, "R6");
        step(1'b0, "R6");
        step(1'b0, "R2");
        // R1: restart moves between edges, outputs must hold until the next edge
        step(1'b1, "R3");
        step(1'b0, "R5");
        restart = 1'b1; #2; check("R1");
        restart = 1'b0; #2; check("R1");
        // restart in each count step
        for (int s = 0; s <= 4; s++) begin
            step(1'b1, "R3");
            for (int j = 0; j <= s; j++) step(1'b0, "");
            step(1'b1, "R4");
        end
        // reset during a count wins over restart
        step(1'b0, "R5");
        step(1'b0, "R5");
        do_reset(1'b1);
        // sweep all 8-cycle restart patterns from reset
        for (int p = 0; p < 256; p++) begin
            do_reset(1'b0);
            for (int b = 0; b < 8; b++) step(p[b], "");
            if (beep !== 1'b0 && cnt !== 3'b100) begin
                n_chk++; n_err++;
                $display("FAIL R7: beep=%b cnt=%b expected cnt=100", beep, cnt);
            end
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule